// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block is the frequency sweep engine of one direct digital synthesis channel, together with the control of that channel's phase accumulator. Software writes a 24-bit channel control word into a shadow register. The word becomes active only when an update strobe arrives. Once active, the word can start a linear sweep. In a sweep, a sweep offset grows by a delta tuning word once per interval of a programmable ramp timer. The output frequency word is the start word plus that offset. The offset stops at the end word. In the optional no-dwell mode it returns to zero instead.

The control word also controls the clearing of the two accumulators. At the update edge, a flag can clear the sweep offset or the phase for exactly one cycle. Separate flags hold either accumulator cleared for as long as they are active. The ramp timer always reloads when it runs out. A flag can make it also reload at the update edge. The phase accumulator adds the frequency word every cycle and wraps. One flag selects sine or cosine for the downstream amplitude stage, and a two-bit field passes the modulation type on to that stage.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: A `ctl_wr` write stores `ctl_wdata` in a shadow register only. The active control word takes the shadow value (as held before that edge) at a clock edge with `upd` high, and changes at no other time. After reset, both words are zero.
- R2: While active bit 14 (sweep) is set, the sweep offset increases by `delta_word` once every `ramp_rate` cycles, and a rate of 0 acts as 1. `freq_out` equals `start_word` plus the offset. While bit 14 is clear, the offset holds.
- R3: When a step would bring the offset to or past `end_word - start_word`, the offset stops at that span, so `freq_out` equals `end_word`. No wraparound occurs, even at the top of the 32-bit range.
- R4: With active bit 15 (no-dwell) also set, reaching the span returns the offset to zero. While bit 14 is clear, bit 15 has no effect.
- R5: The ramp timer reloads from `ramp_rate` when its count is 1 or less, and a step happens at that edge. It also reloads at an update edge when the incoming word has bit 13 set. Without bit 13, the count continues through the update.
- R6: At an update edge where the incoming word has bit 4 set, the sweep offset becomes zero. This wins over a ramp step at the same edge.
- R7: While active bit 3 is set, the sweep offset is held at zero asynchronously, and `freq_out` equals `start_word`.
- R8: At an update edge where the incoming word has bit 2 set, `phase_out` becomes zero for one cycle and then resumes accumulating.
- R9: While active bit 1 is set, `phase_out` is held at zero asynchronously.
- R10: Each cycle, `phase_out` advances by `freq_out`, modulo 2^32.
- R11: `sine_sel` follows active bit 0 (1 = sine, 0 = cosine), and `mod_sel` follows active bits 23:22. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the shadow control word |
| ctl_wdata | input | 24 | Control word to write |
| upd | input | 1 | Update strobe: shadow word becomes active |
| start_word | input | 32 | Sweep start frequency word |
| end_word | input | 32 | Sweep end frequency word |
| delta_word | input | 32 | Increment per ramp interval |
| ramp_rate | input | 16 | Ramp interval in cycles |
| freq_out | output | 32 | Current frequency word |
| phase_out | output | 32 | Phase accumulator |
| sine_sel | output | 1 | 1 = sine, 0 = cosine |
| mod_sel | output | 2 | Modulation type field |

## Verification
Two events can land on the same clock edge: an update strobe that carries the sweep auto-clear flag, and a ramp-timer expiry that would add a step. The bench provokes this by running the timer at rate 1, so that it expires on every edge, and then issuing the clearing update. Just after that edge, the frequency must equal the start word, not start plus delta. One cycle later, the step is expected to come through. A second collision places an update with and without the reload flag in the middle of a countdown, and checks on which edge the next step appears.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   localparam int CTL_W = 24;

   typedef struct packed {
      logic [1:0] mod;
      logic       nodwell;
      logic       sweep;
      logic       reload;
      logic       sw_aclr;
      logic       sw_hclr;
      logic       ph_aclr;
      logic       ph_hclr;
      logic       sine;
   } ctl_t;

   function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
      ctl_t c;
      c.mod     = w[23:22];
      c.nodwell = w[15];
      c.sweep   = w[14];
      c.reload  = w[13];
      c.sw_aclr = w[4];
      c.sw_hclr = w[3];
      c.ph_aclr = w[2];
      c.ph_hclr = w[1];
      c.sine    = w[0];
      return c;
   endfunction
endpackage

// File: rtl/fsw_ctl_regs.sv
module fsw_ctl_regs
   import fsw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             upd,
   output ctl_t             shd,
   output ctl_t             act
);
   logic [CTL_W-1:0] shd_w;
   logic [CTL_W-1:0] act_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_w <= '0;
         act_w <= '0;
      end else begin
         if (wr)  shd_w <= wdata;
         if (upd) act_w <= shd_w;
      end
   end

   assign shd = ctl_decode(shd_w);
   assign act = ctl_decode(act_w);
endmodule

// File: rtl/fsw_ramp_timer.sv
module fsw_ramp_timer #(
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          upd_reload,
   input  logic [RW-1:0] rate,
   output logic          tick
);
   logic [RW-1:0] cnt;
   logic          expired;

   assign expired = (cnt <= RW'(1));
   assign tick    = run && expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (!run || expired || upd_reload) cnt <= rate;
      else                                 cnt <= cnt - RW'(1);
   end
endmodule

// File: rtl/fsw_sweep_acc.sv
module fsw_sweep_acc #(
   parameter int FW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hclr,
   input  logic          aclr,
   input  logic          step,
   input  logic          nodwell,
   input  logic [FW-1:0] start_w,
   input  logic [FW-1:0] stop_w,
   input  logic [FW-1:0] delta,
   output logic [FW-1:0] offset
);
   localparam int SW = FW + 1;

   logic [FW-1:0] span;
   logic [SW-1:0] sum;
   logic          hit;
   logic [FW-1:0] nxt;

   assign span = (stop_w > start_w) ? (stop_w - start_w) : '0;
   assign sum  = {1'b0, offset} + {1'b0, delta};
   assign hit  = (sum >= {1'b0, span});

   always_comb begin
      if (!hit)        nxt = sum[FW-1:0];
      else if (nodwell) nxt = '0;
      else             nxt = span;
   end

   always_ff @(posedge clk or negedge rst_n or posedge hclr) begin
      if (!rst_n)     offset <= '0;
      else if (hclr)  offset <= '0;
      else if (aclr)  offset <= '0;
      else if (step)  offset <= nxt;
   end
endmodule

// File: rtl/fsw_phase_acc.sv
module fsw_phase_acc #(
   parameter int FW = 32,
   parameter int PW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hclr,
   input  logic          aclr,
   input  logic [FW-1:0] freq,
   output logic [PW-1:0] inc,
   output logic [PW-1:0] phase
);
   generate
      if (PW >= FW) begin : g_wide
         assign inc = PW'(freq);
      end else begin : g_narrow
         assign inc = freq[FW-1 -: PW];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n or posedge hclr) begin
      if (!rst_n)     phase <= '0;
      else if (hclr)  phase <= '0;
      else if (aclr)  phase <= '0;
      else            phase <= phase + inc;
   end
endmodule

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl
   import fsw_pkg::*;
#(
   parameter int FW = 32,
   parameter int PW = 32,
   parameter int RW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             upd,
   input  logic [FW-1:0]    start_word,
   input  logic [FW-1:0]    end_word,
   input  logic [FW-1:0]    delta_word,
   input  logic [RW-1:0]    ramp_rate,
   output logic [FW-1:0]    freq_out,
   output logic [PW-1:0]    phase_out,
   output logic             sine_sel,
   output logic [1:0]       mod_sel
);
   generate
      if (FW < 8 || PW < 8 || RW < 1) begin : g_bad_width
         $error("freq_sweep_ctrl: FW and PW must be at least 8, RW at least 1");
      end
   endgenerate

   ctl_t          shd;
   ctl_t          act;
   logic          ramp_tick;
   logic [FW-1:0] sweep_off;
   logic [PW-1:0] ph_inc;

   fsw_ctl_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .upd   (upd),
      .shd   (shd),
      .act   (act)
   );

   fsw_ramp_timer #(.RW(RW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (act.sweep),
      .upd_reload (upd && shd.reload),
      .rate       (ramp_rate),
      .tick       (ramp_tick)
   );

   fsw_sweep_acc #(.FW(FW)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .hclr    (act.sw_hclr),
      .aclr    (upd && shd.sw_aclr),
      .step    (ramp_tick),
      .nodwell (act.nodwell && act.sweep),
      .start_w (start_word),
      .stop_w  (end_word),
      .delta   (delta_word),
      .offset  (sweep_off)
   );

   assign freq_out = start_word + sweep_off;

   fsw_phase_acc #(.FW(FW), .PW(PW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .hclr  (act.ph_hclr),
      .aclr  (upd && shd.ph_aclr),
      .freq  (freq_out),
      .inc   (ph_inc),
      .phase (phase_out)
   );

   assign sine_sel = act.sine;
   assign mod_sel  = act.mod;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker
   import fsw_pkg::*;
#(
   parameter int FW = 32,
   parameter int PW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          upd,
   input ctl_t          shd,
   input ctl_t          act,
   input logic [FW-1:0] sweep_off,
   input logic [FW-1:0] freq_out,
   input logic [FW-1:0] start_word,
   input logic [PW-1:0] phase_out,
   input logic [PW-1:0] ph_inc
);
   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> act == $past(act)); // R1
   AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> act == $past(shd)); // R1
   AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !act.sweep) |=> sweep_off == $past(sweep_off)); // R2
   AST_SWEEP_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && shd.sw_aclr) |=> sweep_off == '0); // R6
   AST_SWEEP_HARDCLR: assert property (@(posedge clk) disable iff (!rst_n)
      act.sw_hclr |-> freq_out == start_word); // R7
   AST_PHASE_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && shd.ph_aclr) |=> phase_out == '0); // R8
   AST_PHASE_HARDCLR: assert property (@(posedge clk) disable iff (!rst_n)
      act.ph_hclr |-> phase_out == '0); // R9
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !act.ph_hclr) |=> phase_out == PW'($past(phase_out) + $past(ph_inc))); // R10
endmodule

bind freq_sweep_ctrl fsw_checker #(.FW(FW), .PW(PW)) u_fsw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd        (upd),
   .shd        (shd),
   .act        (act),
   .sweep_off  (sweep_off),
   .freq_out   (freq_out),
   .start_word (start_word),
   .phase_out  (phase_out),
   .ph_inc     (ph_inc)
);

// File: tb/test_freq_sweep_ctrl.sv
`timescale 1ns/1ps
module test_freq_sweep_ctrl;
   localparam logic [23:0] W_SINE = 24'h000001;
   localparam logic [23:0] W_PHC  = 24'h000002;
   localparam logic [23:0] W_PHA  = 24'h000004;
   localparam logic [23:0] W_SWC  = 24'h000008;
   localparam logic [23:0] W_SWA  = 24'h000010;
   localparam logic [23:0] W_RLD  = 24'h002000;
   localparam logic [23:0] W_SWP  = 24'h004000;
   localparam logic [23:0] W_ND   = 24'h008000;

   typedef struct packed {
      logic [31:0] start;
      logic [31:0] stop;
      logic [31:0] delta;
      logic [15:0] rate;
      logic        nd;
      logic [7:0]  n;
      logic [31:0] expv;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{32'd1000, 32'd2000, 32'd10, 16'd1, 1'b0, 8'd5,  32'd1050},
      '{32'd1000, 32'd2000, 32'd10, 16'd4, 1'b0, 8'd9,  32'd1020},
      '{32'd100,  32'd130,  32'd10, 16'd1, 1'b0, 8'd10, 32'd130},
      '{32'd100,  32'd130,  32'd10, 16'd1, 1'b1, 8'd4,  32'd110},
      '{32'd100,  32'd130,  32'd10, 16'd1, 1'b1, 8'd3,  32'd100},
      '{32'd0,    32'd1000, 32'd7,  16'd0, 1'b0, 8'd3,  32'd21},
      '{32'd500,  32'd900,  32'd50, 16'd3, 1'b0, 8'd2,  32'd500},
      '{32'd500,  32'd900,  32'd50, 16'd3, 1'b0, 8'd3,  32'd550},
      '{32'hFFFF_0000, 32'hFFFF_FFFF, 32'h1000, 16'd2, 1'b0, 8'd40, 32'hFFFF_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [23:0] ctl_wdata = '0;
   logic        upd = 1'b0;
   logic [31:0] start_word = 32'd1234;
   logic [31:0] end_word = 32'd5000;
   logic [31:0] delta_word = 32'd10;
   logic [15:0] ramp_rate = 16'd1;
   logic [31:0] freq_out;
   logic [31:0] phase_out;
   logic        sine_sel;
   logic [1:0]  mod_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   freq_sweep_ctrl i_freq_sweep_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .upd        (upd),
      .start_word (start_word),
      .end_word   (end_word),
      .delta_word (delta_word),
      .ramp_rate  (ramp_rate),
      .freq_out   (freq_out),
      .phase_out  (phase_out),
      .sine_sel   (sine_sel),
      .mod_sel    (mod_sel)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
      n_chk++;
      if (got !== expv) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   // called at a negedge: write edge, then update edge, returns at next negedge
   task automatic wr_upd(input logic [23:0] w);
      ctl_wr = 1'b1; ctl_wdata = w;
      @(negedge clk);
      ctl_wr = 1'b0; upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state, R1 / R11
      repeat (3) @(negedge clk);
      check("R11 reset sine_sel", 32'(sine_sel), 32'd0);
      check("R11 reset mod_sel", 32'(mod_sel), 32'd0);
      check("R1 reset freq_out", freq_out, 32'd1234);
      check("R10 reset phase_out", phase_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: a write without update changes nothing visible
      start_word = 32'd1000; end_word = 32'd5000; delta_word = 32'd10; ramp_rate = 16'd1;
      ctl_wr = 1'b1; ctl_wdata = W_SWP | W_SINE;
      @(negedge clk);
      ctl_wr = 1'b0;
      wait_n(5);
      check("R1 shadow only, sine", 32'(sine_sel), 32'd0);
      check("R1 shadow only, freq", freq_out, 32'd1000);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      check("R1 update applies shadow", 32'(sine_sel), 32'd1);

      // R11: modulation field
      wr_upd(24'h800000);
      check("R11 mod_sel", 32'(mod_sel), 32'd2);
      check("R11 cosine", 32'(sine_sel), 32'd0);

      // table of sweep vectors: R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         start_word = VEC[i].start; end_word = VEC[i].stop;
         delta_word = VEC[i].delta; ramp_rate = VEC[i].rate;
         wr_upd(W_SWP | W_SWA | W_RLD | (VEC[i].nd ? W_ND : 24'h0));
         wait_n(int'(VEC[i].n));
         check($sformatf("R2/R3/R4 vector %0d", i), freq_out, VEC[i].expv);
      end

      // R2 hold when sweep off, R4 no-dwell ignored without sweep
      start_word = 32'd100; end_word = 32'd200; delta_word = 32'd10; ramp_rate = 16'd1;
      wr_upd(W_SWP | W_SWA | W_RLD);
      wait_n(2);
      check("R2 sweeping", freq_out, 32'd120);
      wr_upd(W_ND);
      wait_n(5);
      check("R2/R4 hold with sweep off", freq_out, 32'd140);

      // R6: auto-clear on the same edge as a ramp step
      start_word = 32'd1000; end_word = 32'd5000;
      wr_upd(W_SWP | W_RLD);
      wait_n(3);
      wr_upd(W_SWP | W_SWA);
      check("R6 clear beats step", freq_out, 32'd1000);
      wait_n(1);
      check("R6 resumes after clear", freq_out, 32'd1010);

      // R5: update without reload flag keeps counting
      ramp_rate = 16'd4;
      wr_upd(W_SWP | W_SWA | W_RLD);
      wr_upd(W_SWP | W_SWA);
      wait_n(1);
      check("R5 no reload, before step", freq_out, 32'd1000);
      wait_n(1);
      check("R5 no reload, step", freq_out, 32'd1010);
      // R5: update with reload flag restarts the interval
      wr_upd(W_SWP | W_SWA | W_RLD);
      wr_upd(W_SWP | W_SWA | W_RLD);
      wait_n(3);
      check("R5 reload, before step", freq_out, 32'd1000);
      wait_n(1);
      check("R5 reload, step", freq_out, 32'd1010);

      // R7: hard clear of sweep offset
      ramp_rate = 16'd1;
      wr_upd(W_SWP | W_SWC);
      check("R7 hard clear", freq_out, 32'd1000);
      wait_n(5);
      check("R7 hard clear held", freq_out, 32'd1000);
      wr_upd(W_SWP);
      wait_n(1);
      check("R7 released", freq_out, 32'd1010);

      // R8 / R10: phase auto-clear then accumulate
      start_word = 32'd5;
      wr_upd(W_PHA | W_SWA);
      check("R8 phase auto-clear", phase_out, 32'd0);
      wait_n(3);
      check("R10 phase accumulates", phase_out, 32'd15);

      // R9: phase hard clear
      wr_upd(W_PHC);
      check("R9 phase hard clear", phase_out, 32'd0);
      wait_n(4);
      check("R9 phase hard clear held", phase_out, 32'd0);
      wr_upd(24'h0);
      wait_n(2);
      check("R9 released", phase_out, 32'd10);

      // R10: wraparound
      start_word = 32'h8000_0000;
      wr_upd(W_PHA | W_SWA);
      wait_n(1);
      check("R10 half turn", phase_out, 32'h8000_0000);
      wait_n(1);
      check("R10 wrap", phase_out, 32'd0);

      finish_run();
   end
endmodule